// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an up/down timer that produces symmetric, phase-correct pulse-width modulation. On every timer tick the counter climbs from zero to a ceiling, stays on the ceiling for one tick, then descends to zero and stays there for one tick before climbing again. A four-bit mode code selects the ceiling: one of three fixed values, a software-written capture register, or the active value of compare channel 0.

Each compare channel holds a buffered compare value written through a small register port. The buffered value becomes active only on the tick at which the counter sits on the ceiling, so every waveform period runs from ceiling to ceiling and a rewrite never tears a period. A channel's output level drops when the counter meets the compare value on the way up and rises when it meets it on the way down. The output can be passed through straight or inverted. Sticky flags report the bottom turn, the ceiling turn and compare matches. Software clears them by writing ones.

Top module: `pcp_timer`

## Requirements
- R1: After reset the count is 0 and counting upward, every flag is 0, every channel level is 0 and every output select is 0, so every PWM output is 0.
- R2: Mode code 1 selects a ceiling of 0x00FF, code 2 selects 0x01FF, code 3 selects 0x03FF, code 10 selects the capture register, and code 11 selects channel 0's active compare value. A selected ceiling below 3 is treated as 3. Any other code halts the counter.
- R3: In a running mode each tick with `tick_i` high moves the count by one. The count rises to the ceiling, holds the ceiling for one tick, falls to 0, holds 0 for one tick, and repeats. `cnt_down_o` is 1 while falling. Without a tick the count and direction do not change.
- R4: The overflow flag is set one clock after a tick on which the count is 0 while falling.
- R5: A compare write lands in the channel's buffer. The buffer is copied into the active compare value on the tick at which the counter is at the ceiling while rising. In a halted mode the copy happens on every clock.
- R6: On the ceiling tick in mode 10 the capture flag is set. On the ceiling tick in mode 11 channel 0's compare flag is set.
- R7: A channel's compare flag is set one clock after a tick on which the count equals its active compare value.
- R8: On a match tick the channel level becomes 0 if the counter is rising and 1 if it is falling. Output select 2 drives the level, select 3 drives its inverse, and selects 0 and 1 drive 0.
- R9: In modes 1, 2 and 3 a compare write is ANDed with the selected fixed ceiling before it is stored.
- R10: A channel whose active compare value is above the ceiling never matches. Its flag stays 0 and its level does not change.
- R11: Flags stay set until cleared. Writing a one to a flag bit clears that flag, and a set event in the same clock takes priority.
- R12: Register addresses are 0 for the mode (bits 3:0), 1 for output selects (channel n at bits 2n+1:2n), 2 for capture, 3 for flag clear (bit 0 overflow, bit 1 capture, bit 2+n channel n), and 4+n for channel n's compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timer clock enable: one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | W | Register write data |
| cnt_o | output | W | Current count |
| cnt_down_o | output | 1 | 1 while counting down |
| pwm_o | output | NCH | PWM output per channel |
| ovf_flag_o | output | 1 | Bottom-turn flag |
| cap_flag_o | output | 1 | Ceiling flag in capture-ceiling mode |
| cmp_flag_o | output | NCH | Compare match flag per channel |

## Verification
The count, direction, channel levels, flags and buffer contents are all registered. Each one shows the effect of a tick or write on the first rising edge after it is presented. An active compare value changes only on the edge that ends a ceiling tick, so it can first produce a match on the following tick. The bench presents inputs after a falling edge and steps a model of the count on the same rising edge as the design. It compares every output at the next falling edge, so each result is checked in the cycle it is due. Directed cases check tick-gating, masking, mid-period rewrites and flag clearing at a fixed number of edges after their stimulus.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  // mode codes
  localparam logic [3:0] MD_HALT  = 4'd0;
  localparam logic [3:0] MD_FIX8  = 4'd1;
  localparam logic [3:0] MD_FIX9  = 4'd2;
  localparam logic [3:0] MD_FIX10 = 4'd3;
  localparam logic [3:0] MD_CAPT  = 4'd10;
  localparam logic [3:0] MD_CMPA  = 4'd11;

  // output select codes
  localparam logic [1:0] OS_STRAIGHT = 2'd2;
  localparam logic [1:0] OS_INVERT   = 2'd3;

  // register addresses
  localparam int RA_MODE = 0;
  localparam int RA_OSEL = 1;
  localparam int RA_CAPT = 2;
  localparam int RA_FCLR = 3;
  localparam int RA_CMP0 = 4;

  // flag bit positions in the clear register
  localparam int FB_OVF  = 0;
  localparam int FB_CAP  = 1;
  localparam int FB_CMP0 = 2;

  function automatic logic mode_fixed(input logic [3:0] m);
    return (m == MD_FIX8) || (m == MD_FIX9) || (m == MD_FIX10);
  endfunction

  function automatic logic mode_runs(input logic [3:0] m);
    return mode_fixed(m) || (m == MD_CAPT) || (m == MD_CMPA);
  endfunction
endpackage

// File: rtl/pcp_rst_sync.sv
module pcp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/pcp_counter.sv
module pcp_counter import pcp_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] capt_i,
  input  logic [W-1:0] cmpa_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         run_o,
  output logic         step_o,
  output logic [W-1:0] top_o,
  output logic         top_ev_o,
  output logic         bot_ev_o
);
  localparam logic [W-1:0] MIN_TOP = W'(3);
  localparam logic [W-1:0] TOP8    = W'(16'h00FF);
  localparam logic [W-1:0] TOP9    = W'(16'h01FF);
  localparam logic [W-1:0] TOP10   = W'(16'h03FF);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic [W-1:0] top_raw, top;
  logic         run, step, at_top, at_bot;

  always_comb begin
    case (mode_i)
      MD_FIX8:  top_raw = TOP8;
      MD_FIX9:  top_raw = TOP9;
      MD_FIX10: top_raw = TOP10;
      MD_CAPT:  top_raw = capt_i;
      MD_CMPA:  top_raw = cmpa_i;
      default:  top_raw = '1;
    endcase
    top = (top_raw < MIN_TOP) ? MIN_TOP : top_raw;
  end

  assign run    = mode_runs(mode_i);
  assign step   = tick_i && run;
  assign at_top = !down_q && (cnt_q >= top);
  assign at_bot = down_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (at_top) begin
      cnt_d  = cnt_q - W'(1);
      down_d = 1'b1;
    end else if (at_bot) begin
      cnt_d  = W'(1);
      down_d = 1'b0;
    end else if (down_q) begin
      cnt_d  = cnt_q - W'(1);
    end else begin
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign down_o   = down_q;
  assign run_o    = run;
  assign step_o   = step;
  assign top_o    = top;
  assign top_ev_o = step && at_top;
  assign bot_ev_o = step && at_bot;

  AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down_q && (cnt_q < top)) |=> (cnt_q == $past(cnt_q) + W'(1))); // R3
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_top) |=> (down_q && (cnt_q == $past(cnt_q) - W'(1)))); // R3
  AST_TURN_AT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_bot) |=> (!down_q && (cnt_q == W'(1)))); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(cnt_q) && $stable(down_q))); // R3
endmodule

// File: rtl/pcp_channel.sv
module pcp_channel import pcp_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         copy_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic [1:0]   osel_i,
  output logic [W-1:0] act_o,
  output logic         match_o,
  output logic         pwm_o
);
  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;
  logic         lvl_q;
  logic         match;

  assign match = step_i && (cnt_i == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_i) begin
      buf_q <= wr_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (copy_i) begin
      act_q <= buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (match) begin
      lvl_q <= down_i;
    end
  end

  always_comb begin
    case (osel_i)
      OS_STRAIGHT: pwm_o = lvl_q;
      OS_INVERT:   pwm_o = ~lvl_q;
      default:     pwm_o = 1'b0;
    endcase
  end

  assign act_o   = act_q;
  assign match_o = match;

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_i |=> $stable(act_q)); // R5
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(lvl_q)); // R8
  AST_RISING_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !down_i && (osel_i == OS_STRAIGHT) && $stable(osel_i)) |=> !pwm_o); // R8
endmodule

// File: rtl/pcp_timer.sv
module pcp_timer import pcp_pkg::*; #(
  parameter int W   = 16,
  parameter int NCH = 3,
  parameter int AW  = $clog2(NCH + 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [W-1:0]   cnt_o,
  output logic           cnt_down_o,
  output logic [NCH-1:0] pwm_o,
  output logic           ovf_flag_o,
  output logic           cap_flag_o,
  output logic [NCH-1:0] cmp_flag_o
);
  localparam int OSW = 2 * NCH;

  logic             rst_sync_n;
  logic [3:0]       mode_q;
  logic [OSW-1:0]   osel_q;
  logic [W-1:0]     capt_q;
  logic             ovf_q, ovf_d;
  logic             capf_q, capf_d;
  logic [NCH-1:0]   cmpf_q, cmpf_d;

  logic [W-1:0]     cnt, top, mask, wr_val, clr;
  logic             down, run, step, top_ev, bot_ev, copy;
  logic             wr_mode, wr_osel, wr_capt, wr_fclr;
  logic [NCH-1:0]   match;
  logic [W-1:0]     act [NCH];

  pcp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_mode = wr_en_i && (wr_addr_i == AW'(RA_MODE));
  assign wr_osel = wr_en_i && (wr_addr_i == AW'(RA_OSEL));
  assign wr_capt = wr_en_i && (wr_addr_i == AW'(RA_CAPT));
  assign wr_fclr = wr_en_i && (wr_addr_i == AW'(RA_FCLR));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MD_HALT;
    end else if (wr_mode) begin
      mode_q <= wr_data_i[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      osel_q <= '0;
    end else if (wr_osel) begin
      osel_q <= wr_data_i[OSW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      capt_q <= '0;
    end else if (wr_capt) begin
      capt_q <= wr_data_i;
    end
  end

  pcp_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick_i),
    .mode_i   (mode_q),
    .capt_i   (capt_q),
    .cmpa_i   (act[0]),
    .cnt_o    (cnt),
    .down_o   (down),
    .run_o    (run),
    .step_o   (step),
    .top_o    (top),
    .top_ev_o (top_ev),
    .bot_ev_o (bot_ev)
  );

  // fixed ceilings are all-ones patterns, so the ceiling itself is the mask
  assign mask   = mode_fixed(mode_q) ? top : '1;
  assign wr_val = wr_data_i & mask;
  assign copy   = top_ev || !run;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pcp_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .step_i   (step),
      .copy_i   (copy),
      .wr_i     (wr_en_i && (wr_addr_i == AW'(RA_CMP0 + ch))),
      .wr_val_i (wr_val),
      .cnt_i    (cnt),
      .down_i   (down),
      .osel_i   (osel_q[2*ch +: 2]),
      .act_o    (act[ch]),
      .match_o  (match[ch]),
      .pwm_o    (pwm_o[ch])
    );
  end

  assign clr = wr_fclr ? wr_data_i : '0;

  always_comb begin
    ovf_d  = (ovf_q & ~clr[FB_OVF]) | bot_ev;
    capf_d = (capf_q & ~clr[FB_CAP]) | (top_ev && (mode_q == MD_CAPT));
    for (int ch = 0; ch < NCH; ch++) begin
      cmpf_d[ch] = (cmpf_q[ch] & ~clr[FB_CMP0 + ch]) | match[ch];
    end
    cmpf_d[0] = cmpf_d[0] | (top_ev && (mode_q == MD_CMPA));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_q  <= 1'b0;
      capf_q <= 1'b0;
      cmpf_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      capf_q <= capf_d;
      cmpf_q <= cmpf_d;
    end
  end

  assign cnt_o      = cnt;
  assign cnt_down_o = down;
  assign ovf_flag_o = ovf_q;
  assign cap_flag_o = capf_q;
  assign cmp_flag_o = cmpf_q;

  AST_OVF_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bot_ev |=> ovf_flag_o); // R4
  AST_CAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (top_ev && (mode_q == MD_CAPT)) |=> cap_flag_o); // R6
  AST_CMPA_AT_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (top_ev && (mode_q == MD_CMPA)) |=> cmp_flag_o[0]); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_flag_o && !(wr_fclr && wr_data_i[FB_OVF])) |=> ovf_flag_o); // R11
endmodule

// File: tb/pcp_timer_tb_top.sv
`timescale 1ns/100ps
module pcp_timer_tb_top;
  localparam int W   = 16;
  localparam int NCH = 3;
  localparam int AW  = 3;

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] capt;
    logic [15:0] c0;
    logic [15:0] c1;
    logic [15:0] c2;
    logic [5:0]  osel;
    logic [15:0] ncyc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 16'd1,  16'd1,     16'd2,     16'd3,     6'b10_11_10, 16'd40},
    '{4'd10, 16'd20, 16'd5,     16'd10,    16'd25,    6'b10_11_10, 16'd100},
    '{4'd11, 16'd0,  16'd12,    16'd4,     16'd12,    6'b11_10_11, 16'd80},
    '{4'd1,  16'd0,  16'h0080,  16'h0010,  16'h00FF,  6'b11_10_10, 16'd1100},
    '{4'd2,  16'd0,  16'h0100,  16'h01FF,  16'h0000,  6'b10_10_11, 16'd2200},
    '{4'd3,  16'd0,  16'h0200,  16'h03FF,  16'h0001,  6'b01_11_10, 16'd2200}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick_i;
  logic           wr_en_i;
  logic [AW-1:0]  wr_addr_i;
  logic [W-1:0]   wr_data_i;
  logic [W-1:0]   cnt_o;
  logic           cnt_down_o;
  logic [NCH-1:0] pwm_o;
  logic           ovf_flag_o;
  logic           cap_flag_o;
  logic [NCH-1:0] cmp_flag_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pcp_timer #(.W(W), .NCH(NCH), .AW(AW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cnt_o      (cnt_o),
    .cnt_down_o (cnt_down_o),
    .pwm_o      (pwm_o),
    .ovf_flag_o (ovf_flag_o),
    .cap_flag_o (cap_flag_o),
    .cmp_flag_o (cmp_flag_o)
  );

  // ---------------- reference model of the requirements ----------------
  logic [15:0] m_cnt, m_capt;
  logic        m_down;
  logic [3:0]  m_mode;
  logic [5:0]  m_osel;
  logic [15:0] m_buf [NCH];
  logic [15:0] m_act [NCH];
  logic        m_lvl [NCH];
  logic        m_ovf, m_capf;
  logic [NCH-1:0] m_cmpf;

  logic        m_run, m_fixed, m_step, m_attop, m_atbot;
  logic [15:0] m_top, m_raw;
  logic [NCH-1:0] m_match;

  always_comb begin
    m_fixed = (m_mode == 4'd1) || (m_mode == 4'd2) || (m_mode == 4'd3);
    m_run   = m_fixed || (m_mode == 4'd10) || (m_mode == 4'd11);
    case (m_mode)
      4'd1:    m_raw = 16'h00FF;
      4'd2:    m_raw = 16'h01FF;
      4'd3:    m_raw = 16'h03FF;
      4'd10:   m_raw = m_capt;
      4'd11:   m_raw = m_act[0];
      default: m_raw = 16'hFFFF;
    endcase
    m_top   = (m_raw < 16'd3) ? 16'd3 : m_raw;
    m_step  = tick_i && m_run;
    m_attop = m_step && !m_down && (m_cnt >= m_top);
    m_atbot = m_step && m_down && (m_cnt == 16'd0);
    for (int c = 0; c < NCH; c++) m_match[c] = m_step && (m_cnt == m_act[c]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_down <= 1'b0; m_mode <= '0; m_osel <= '0; m_capt <= '0;
      m_ovf <= 1'b0; m_capf <= 1'b0; m_cmpf <= '0;
      for (int c = 0; c < NCH; c++) begin
        m_buf[c] <= '0; m_act[c] <= '0; m_lvl[c] <= 1'b0;
      end
    end else begin
      if (m_step) begin
        if (m_attop) begin m_cnt <= m_cnt - 16'd1; m_down <= 1'b1; end
        else if (m_atbot) begin m_cnt <= 16'd1; m_down <= 1'b0; end
        else if (m_down) m_cnt <= m_cnt - 16'd1;
        else m_cnt <= m_cnt + 16'd1;
      end
      for (int c = 0; c < NCH; c++) begin
        if (m_attop || !m_run) m_act[c] <= m_buf[c];
        if (m_match[c]) m_lvl[c] <= m_down;
      end
      m_ovf  <= (m_ovf & ~(wr_en_i && wr_addr_i == 3'd3 && wr_data_i[0])) | m_atbot;
      m_capf <= (m_capf & ~(wr_en_i && wr_addr_i == 3'd3 && wr_data_i[1])) |
                (m_attop && m_mode == 4'd10);
      for (int c = 0; c < NCH; c++)
        m_cmpf[c] <= (m_cmpf[c] & ~(wr_en_i && wr_addr_i == 3'd3 && wr_data_i[2+c])) |
                     m_match[c] | (c == 0 && m_attop && m_mode == 4'd11);
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: m_mode <= wr_data_i[3:0];
          3'd1: m_osel <= wr_data_i[5:0];
          3'd2: m_capt <= wr_data_i;
          3'd4: m_buf[0] <= m_fixed ? (wr_data_i & m_top) : wr_data_i;
          3'd5: m_buf[1] <= m_fixed ? (wr_data_i & m_top) : wr_data_i;
          3'd6: m_buf[2] <= m_fixed ? (wr_data_i & m_top) : wr_data_i;
          default: ;
        endcase
      end
    end
  end

  function automatic logic m_pwm(input int c);
    case (m_osel[2*c +: 2])
      2'd2:    return m_lvl[c];
      2'd3:    return ~m_lvl[c];
      default: return 1'b0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [NCH-1:0] ep;
    for (int c = 0; c < NCH; c++) ep[c] = m_pwm(c);
    chk("R2/R3", "count", 32'(cnt_o), 32'(m_cnt));
    chk("R3", "direction", 32'(cnt_down_o), 32'(m_down));
    chk("R8", "pwm", 32'(pwm_o), 32'(ep));
    chk("R4", "overflow flag", 32'(ovf_flag_o), 32'(m_ovf));
    chk("R6", "capture flag", 32'(cap_flag_o), 32'(m_capf));
    chk("R7", "compare flags", 32'(cmp_flag_o), 32'(m_cmpf));
  endtask

  // called right after a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
    check_all();
  endtask

  task automatic run(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check_all();
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b1; tick_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "reset count", 32'(cnt_o), 32'd0);
    chk("R1", "reset direction", 32'(cnt_down_o), 32'd0);
    chk("R1", "reset pwm", 32'(pwm_o), 32'd0);
    chk("R1", "reset flags", 32'({ovf_flag_o, cap_flag_o, cmp_flag_o}), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      tick_i = 1'b0;
      wr(3'd0, 16'd0);                       // halt: compare writes go straight through
      wr(3'd1, 16'(VECS[v].osel));
      wr(3'd2, VECS[v].capt);
      wr(3'd4, VECS[v].c0);
      wr(3'd5, VECS[v].c1);
      wr(3'd6, VECS[v].c2);
      wr(3'd3, 16'h001F);
      wr(3'd0, 16'(VECS[v].mode));
      run(int'(VECS[v].ncyc));
      tick_i = 1'b0;
      if (v == 1) chk("R10", "compare above ceiling flag", 32'(cmp_flag_o[2]), 32'd0);
      if (v == 2) chk("R6", "ceiling flag in compare-A mode", 32'(cmp_flag_o[0]), 32'd1);
    end

    // R3: no tick, no movement
    begin
      logic [15:0] c0;
      logic        d0;
      tick_i = 1'b0;
      c0 = cnt_o; d0 = cnt_down_o;
      repeat (8) @(negedge clk);
      chk("R3", "count held without tick", 32'(cnt_o), 32'(c0));
      chk("R3", "direction held without tick", 32'(cnt_down_o), 32'(d0));
    end

    // R9: mask on write in fixed mode 1
    tick_i = 1'b0;
    wr(3'd0, 16'd1);
    wr(3'd6, 16'h1234);
    wr(3'd3, 16'h001F);
    run(1600);
    chk("R9", "masked compare matched", 32'(cmp_flag_o[2]), 32'd1);

    // R5: rewrite mid-period must wait for the ceiling
    tick_i = 1'b0;
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd20);
    wr(3'd5, 16'd5);
    wr(3'd0, 16'd10);
    for (int i = 0; i < 200 && !(m_cnt == 16'd2 && !m_down); i++) run(1);
    wr(3'd5, 16'd15);
    wr(3'd3, 16'h001F);
    for (int i = 0; i < 40 && !(m_cnt == 16'd10 && !m_down); i++) run(1);
    chk("R5", "old compare still active after rewrite", 32'(cmp_flag_o[1]), 32'd1);
    run(60);

    // R11 / R12: clear only the overflow bit
    tick_i = 1'b0;
    begin
      logic capf0;
      logic [NCH-1:0] cmpf0;
      chk("R4", "overflow set before clear", 32'(ovf_flag_o), 32'd1);
      capf0 = cap_flag_o; cmpf0 = cmp_flag_o;
      wr(3'd3, 16'h0001);
      chk("R11", "overflow cleared by write-one", 32'(ovf_flag_o), 32'd0);
      chk("R12", "other flags untouched by bit-0 clear",
          32'({cap_flag_o, cmp_flag_o}), 32'({capf0, cmpf0}));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule